// File: doc/BRIEF.md
# Four-Unit Feedback Datapath

A small synchronous datapath built from four function units. Each unit owns one 16-bit result register. It takes its two operands from a shared pool of seven values: the external sample, the constants zero and one, and the current contents of all four result registers. Because the registers feed back into the pool, a chain of operations over several cycles can be built by steering operand addresses alone.

On each qualified cycle the caller supplies one external sample and one opcode for the configurable unit. It also supplies one operand-address pair per unit. Unit 1 adds, unit 2 subtracts and unit 3 multiplies, all with 16-bit wrap-around. Unit 0 shifts, exclusive-ors or compares, depending on the opcode. The block output is the unit 3 register. An address outside the pool reads as zero and latches a sticky error indication.

Top module: `fuq_datapath`

## Requirements
- R1: A synchronous active-high reset clears all four result registers and the error flag. After the reset edge, `out_result` and `out_addr_err` read 0.
- R2: `out_result` is the unit 3 register. The product from the operands presented at a qualified edge appears after that edge and stays there until the next qualified edge.
- R3: Operand addresses select from the pool as follows. 0 is the external sample. 1 is the constant 0. 2 is the constant 1. 3, 4, 5 and 6 are the registers of units 0, 1, 2 and 3. In `in_addr`, unit k's pair occupies bits [6k+5:6k]: the first-operand address is in bits [6k+2:6k] and the second-operand address is in bits [6k+5:6k+3].
- R4: Unit 1 stores first+second and unit 2 stores first−second, both wrapping modulo 2^16.
- R5: Unit 3 stores the low 16 bits of first×second.
- R6: With opcode 00, unit 0 stores the first operand shifted left logically by the second operand, taken as an unsigned count. A count of 16 or more gives 0.
- R7: With opcode 01, unit 0 stores the bitwise exclusive-or of its operands.
- R8: With opcode 10, unit 0 stores 1 when its operands are equal and 0 otherwise.
- R9: With opcode 11, unit 0 stores 0.
- R10: Address 7 reads as 0. On a qualified cycle it sets `out_addr_err`, which stays 1 until reset.
- R11: While `in_valid` is 0, no register changes and the error flag is not set, whatever the other inputs are.
- R12: All four registers update on the same edge, and every operand is read from the values held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the cycle's inputs; registers update only when 1 |
| in_sample | input | 16 | External sample, pool entry 0 |
| in_op | input | 2 | Unit 0 opcode: 00 shift, 01 xor, 10 equal, 11 zero |
| in_addr | input | 24 | Four operand-address pairs, 6 bits per unit |
| out_result | output | 16 | Unit 3 result register |
| out_addr_err | output | 1 | Sticky out-of-range address flag |

## Verification
Two functions can land on the same edge. One is a register's own update, the other is another unit reading that register as an operand. The check of R12 provokes this by having unit 1 increment itself while unit 3 copies unit 1's register on every cycle; the output must trail the counter by exactly one step. The hold and error tests also combine two functions in one cycle. An invalid cycle carries an out-of-range address, and the test confirms that neither the output nor the error flag moves.

// File: rtl/fuq_pkg.sv
package fuq_pkg;
   localparam int NUM_UNITS = 4;
   localparam int NUM_SRC   = NUM_UNITS + 3;
   localparam int SEL_W     = $clog2(NUM_SRC + 1);

   localparam int SRC_EXT  = 0;
   localparam int SRC_ZERO = 1;
   localparam int SRC_ONE  = 2;
   localparam int SRC_REG0 = 3;

   typedef enum logic [1:0] {
      U0_SHL = 2'b00,
      U0_XOR = 2'b01,
      U0_EQ  = 2'b10,
      U0_RSV = 2'b11
   } u0_op_e;

   typedef enum int {
      KIND_ADD = 1,
      KIND_SUB = 2,
      KIND_MUL = 3
   } unit_kind_e;
endpackage

// File: rtl/fuq_operand_sel.sv
module fuq_operand_sel #(
   parameter int DW    = 16,
   parameter int NSRC  = 7,
   parameter int SEL_W = 3
) (
   input  logic [NSRC*DW-1:0] pool,
   input  logic [SEL_W-1:0]   sel,
   output logic [DW-1:0]      data,
   output logic               bad
);
   initial begin
      a_sel_fits : assert ((1 << SEL_W) >= NSRC) else $error("select width too small");
   end

   always_comb begin
      data = '0;
      bad  = 1'b1;
      for (int i = 0; i < NSRC; i++) begin
         if (sel == SEL_W'(i)) begin
            data = pool[i*DW +: DW];
            bad  = 1'b0;
         end
      end
   end
endmodule

// File: rtl/fuq_cfg_unit.sv
module fuq_cfg_unit
   import fuq_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  u0_op_e        op,
   output logic [DW-1:0] y
);
   localparam int SHW = $clog2(DW);

   initial begin
      a_dw_pow2 : assert ((1 << SHW) == DW) else $error("unit 0 width must be a power of two");
   end

   always_comb begin
      unique case (op)
         U0_SHL:  y = (b >= DW[DW-1:0] || DW < 2) ? '0 : (a << b[SHW-1:0]);
         U0_XOR:  y = a ^ b;
         U0_EQ:   y = {{(DW-1){1'b0}}, (a == b)};
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/fuq_fixed_unit.sv
module fuq_fixed_unit
   import fuq_pkg::*;
#(
   parameter int DW   = 16,
   parameter int KIND = KIND_ADD
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);
   generate
      if (KIND == KIND_ADD) begin : g_add
         assign y = a + b;
      end else if (KIND == KIND_SUB) begin : g_sub
         assign y = a - b;
      end else if (KIND == KIND_MUL) begin : g_mul
         assign y = a * b;
      end else begin : g_bad
         assign y = '0;
         initial begin
            a_kind_known : assert (0) else $error("unknown unit kind");
         end
      end
   endgenerate
endmodule

// File: rtl/fuq_datapath.sv
module fuq_datapath
   import fuq_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             in_valid,
   input  logic [DW-1:0]                    in_sample,
   input  logic [1:0]                       in_op,
   input  logic [NUM_UNITS*2*SEL_W-1:0]     in_addr,
   output logic [DW-1:0]                    out_result,
   output logic                             out_addr_err
);
   localparam int PAIR_W = 2 * SEL_W;

   initial begin
      a_dw_range : assert (DW >= 4 && DW <= 64) else $error("data width out of range");
   end

   logic [DW-1:0]            q   [NUM_UNITS];
   logic [DW-1:0]            res [NUM_UNITS];
   logic [NUM_SRC*DW-1:0]    pool;
   logic [2*NUM_UNITS-1:0]   bad_v;
   logic                     err_q;

   always_comb begin
      pool = '0;
      pool[SRC_EXT*DW  +: DW] = in_sample;
      pool[SRC_ZERO*DW +: DW] = '0;
      pool[SRC_ONE*DW  +: DW] = DW'(1);
      for (int k = 0; k < NUM_UNITS; k++)
         pool[(SRC_REG0+k)*DW +: DW] = q[k];
   end

   for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
      logic [DW-1:0] opa, opb;
      logic [PAIR_W-1:0] pair;
      assign pair = in_addr[k*PAIR_W +: PAIR_W];

      fuq_operand_sel #(.DW(DW), .NSRC(NUM_SRC), .SEL_W(SEL_W)) u_sel_a (
         .pool(pool), .sel(pair[SEL_W-1:0]), .data(opa), .bad(bad_v[2*k]));
      fuq_operand_sel #(.DW(DW), .NSRC(NUM_SRC), .SEL_W(SEL_W)) u_sel_b (
         .pool(pool), .sel(pair[PAIR_W-1:SEL_W]), .data(opb), .bad(bad_v[2*k+1]));

      if (k == 0) begin : g_cfg
         fuq_cfg_unit #(.DW(DW)) u_fu (
            .a(opa), .b(opb), .op(u0_op_e'(in_op)), .y(res[k]));
      end else begin : g_fix
         fuq_fixed_unit #(.DW(DW), .KIND(k)) u_fu (
            .a(opa), .b(opb), .y(res[k]));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NUM_UNITS; k++) q[k] <= '0;
         err_q <= 1'b0;
      end else if (in_valid) begin
         for (int k = 0; k < NUM_UNITS; k++) q[k] <= res[k];
         err_q <= err_q | (|bad_v);
      end
   end

   assign out_result   = q[NUM_UNITS-1];
   assign out_addr_err = err_q;

   // R1: reset clears output and flag
   p_reset_clear_r1 : assert property (@(posedge clk)
      rst |=> (out_result == '0 && !out_addr_err));

   // R2: output carries the unit 3 result of the last qualified edge
   p_out_lag_r2 : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_result == $past(res[NUM_UNITS-1]));

   // R8: equal opcode yields only 0 or 1
   p_eq_bool_r8 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == U0_EQ) |=> (q[0] <= DW'(1)));

   // R9: reserved opcode yields zero
   p_rsv_zero_r9 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == U0_RSV) |=> q[0] == '0);

   // R10: error flag is sticky
   p_err_sticky_r10 : assert property (@(posedge clk) disable iff (rst)
      out_addr_err |=> out_addr_err);

   // R11: unqualified cycles change nothing
   p_hold_r11 : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_result) && $stable(out_addr_err)));
endmodule

// File: tb/fuq_datapath_test.sv
module fuq_datapath_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] EXT = 3'd0, ZRO = 3'd1, ONE = 3'd2,
                          R0 = 3'd3, R1 = 3'd4, R2 = 3'd5, R3 = 3'd6, BAD = 3'd7;
   localparam logic [1:0] OP_SHL = 2'b00, OP_XOR = 2'b01, OP_EQ = 2'b10, OP_RSV = 2'b11;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_sample = '0;
   logic [1:0]  in_op = OP_XOR;
   logic [23:0] in_addr = '0;
   logic [15:0] out_result;
   logic        out_addr_err;

   int n_checks = 0;
   int n_fails  = 0;

   fuq_datapath uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .in_op(in_op), .in_addr(in_addr),
      .out_result(out_result), .out_addr_err(out_addr_err));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [23:0] pk(logic [2:0] a0, logic [2:0] b0, logic [2:0] a1, logic [2:0] b1,
                                      logic [2:0] a2, logic [2:0] b2, logic [2:0] a3, logic [2:0] b3);
      return {b3, a3, b2, a2, b1, a1, b0, a0};
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(logic v, logic [15:0] s, logic [1:0] op, logic [23:0] ad);
      @(negedge clk);
      in_valid = v; in_sample = s; in_op = op; in_addr = ad;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      @(posedge clk);
      #1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // unit 3 copies register of unit k (idx 3+k) times one
   task automatic route(logic [2:0] src);
      cyc(1'b1, 16'h0, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, src, ONE));
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 out after reset", out_result, 16'h0);
      check("R1 err after reset", {15'h0, out_addr_err}, 16'h0);
   endtask

   task automatic t_mul();
      do_reset();
      cyc(1'b1, 16'd300, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, EXT));
      check("R5 300*300 low bits", out_result, 16'd24464);
      cyc(1'b1, 16'hFFFD, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, EXT));
      check("R5 (-3)*(-3)", out_result, 16'd9);
      cyc(1'b0, 16'd7, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, EXT));
      check("R2 output held until next qualified edge", out_result, 16'd9);
   endtask

   task automatic t_const();
      do_reset();
      cyc(1'b1, 16'd9, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, ONE, ONE));
      check("R3 index 2 is one", out_result, 16'd1);
      cyc(1'b1, 16'd9, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT));
      check("R3 index 1 is zero", out_result, 16'd0);
      cyc(1'b1, 16'h1234, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, ONE));
      check("R3 index 0 is sample", out_result, 16'h1234);
   endtask

   task automatic t_addsub();
      do_reset();
      cyc(1'b1, 16'h7FFF, OP_XOR, pk(ZRO, ZRO, EXT, EXT, ZRO, ZRO, ZRO, ZRO));
      route(R1);
      check("R4 add wraps", out_result, 16'hFFFE);
      cyc(1'b1, 16'd5, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, EXT, ZRO, ZRO));
      route(R2);
      check("R4 subtract second from first", out_result, 16'hFFFB);
   endtask

   task automatic t_shift();
      do_reset();
      cyc(1'b1, 16'd3, OP_SHL, pk(EXT, ONE, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      route(R0);
      check("R6 shift by 1", out_result, 16'd6);
      cyc(1'b1, 16'd15, OP_XOR, pk(ZRO, ZRO, EXT, ZRO, ZRO, ZRO, ZRO, ZRO));
      cyc(1'b1, 16'd1, OP_SHL, pk(EXT, R1, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      route(R0);
      check("R6 shift by 15", out_result, 16'h8000);
      cyc(1'b1, 16'd16, OP_XOR, pk(EXT, ZRO, EXT, ZRO, ZRO, ZRO, ZRO, ZRO));
      cyc(1'b1, 16'd3, OP_SHL, pk(EXT, R1, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      route(R0);
      check("R6 shift by 16 gives zero", out_result, 16'd0);
   endtask

   task automatic t_xor();
      do_reset();
      cyc(1'b1, 16'h0F0F, OP_XOR, pk(EXT, ONE, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      route(R0);
      check("R7 xor", out_result, 16'h0F0E);
   endtask

   task automatic t_eq();
      do_reset();
      cyc(1'b1, 16'd5, OP_EQ, pk(EXT, EXT, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      route(R0);
      check("R8 equal operands", out_result, 16'd1);
      cyc(1'b1, 16'd5, OP_EQ, pk(EXT, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      route(R0);
      check("R8 unequal operands", out_result, 16'd0);
   endtask

   task automatic t_rsv();
      do_reset();
      cyc(1'b1, 16'd7, OP_XOR, pk(EXT, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      cyc(1'b1, 16'd7, OP_RSV, pk(EXT, EXT, ZRO, ZRO, ZRO, ZRO, ZRO, ZRO));
      route(R0);
      check("R9 reserved opcode gives zero", out_result, 16'd0);
   endtask

   task automatic t_hold();
      do_reset();
      cyc(1'b1, 16'h0055, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, ONE));
      check("R11 setup value", out_result, 16'h0055);
      cyc(1'b0, 16'h0099, OP_XOR, pk(BAD, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, ONE));
      check("R11 output held when invalid", out_result, 16'h0055);
      check("R11 no error when invalid", {15'h0, out_addr_err}, 16'h0);
      route(R3);
      check("R11 unit 3 register unchanged", out_result, 16'h0055);
   endtask

   task automatic t_feedback();
      do_reset();
      for (int i = 0; i < 3; i++) begin
         cyc(1'b1, 16'h0, OP_XOR, pk(ZRO, ZRO, R1, ONE, ZRO, ZRO, R1, ONE));
         check("R12 output trails self-incrementing unit 1", out_result, 16'(i));
      end
   endtask

   task automatic t_bad();
      do_reset();
      cyc(1'b1, 16'd9, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, ONE));
      check("R10 flag clear before bad address", {15'h0, out_addr_err}, 16'h0);
      cyc(1'b1, 16'd9, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, BAD, ONE));
      check("R10 address 7 reads zero", out_result, 16'd0);
      check("R10 flag set", {15'h0, out_addr_err}, 16'h1);
      cyc(1'b1, 16'd4, OP_XOR, pk(ZRO, ZRO, ZRO, ZRO, ZRO, ZRO, EXT, ONE));
      check("R10 flag sticky", {15'h0, out_addr_err}, 16'h1);
      check("R10 datapath continues", out_result, 16'd4);
      do_reset();
      check("R1 reset clears sticky flag", {15'h0, out_addr_err}, 16'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      t_reset();
      t_mul();
      t_const();
      t_addsub();
      t_shift();
      t_xor();
      t_eq();
      t_rsv();
      t_hold();
      t_feedback();
      t_bad();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule